// File: doc/BRIEF.md
# Set-Associative LRU Tag Directory

This block tracks hit and miss outcomes for a write-allocate, set-associative cache without holding any data. A request carries a byte address and an access size in bytes. The block works out whether the access stays inside one cache line or runs into the next line. It looks up each touched set, keeps recency by physically reordering the tags of that set, and returns exactly one outcome per request. A saturating counter accumulates the misses.

The geometry comes from three power-of-two parameters: total size, line size and number of ways. There are `SETS = CACHE_BYTES / LINE_BYTES / WAYS` sets. Inside each set the tags are kept as a list ordered by recency, with the newest tag in way 0.

The control is a three-state machine.
- `ST_IDLE`: the block is ready. The transition *accept* captures the decoded request and moves to `ST_FIRST`.
- `ST_FIRST`: the block looks up the first set. From here, *finish_single* and *finish_error* return to `ST_IDLE`, and *continue_span* moves to `ST_SECOND`.
- `ST_SECOND`: the block looks up the neighbouring set. The transition *finish_span* returns to `ST_IDLE`.

Top module: `tagdir_lru`

## Requirements
- R1: The set index is the address field of log2(SETS) bits that sits just above the log2(LINE_BYTES) offset bits. The tag is the address shifted right by log2(LINE_BYTES)+log2(SETS).
- R2: Reset clears every stored tag and the miss count to zero, raises `req_ready` and lowers `done`. As a result, a lookup of tag 0 right after reset is a hit.
- R3: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the result appears. `done` is a pulse of exactly one cycle. It is registered on the second edge after acceptance for a one-line access or an error, and on the third edge for a two-line access.
- R4: While `done` is high, exactly one of `hit`, `miss` and `err` is high. While `done` is low, all three are low.
- R5: A hit in way i moves that tag into way 0, and ways 0 to i-1 each move down by one way.
- R6: A miss moves every way down by one, drops the tag held in the last way, and writes the new tag into way 0. Every access allocates on a miss.
- R7: The second set is taken from address + size - 1, where size is at least 1. If it equals the first set, the request is a one-line access. If it equals (first set + 1) mod SETS, including the wrap from the last set to set 0, the two sets are updated one after the other, first set first, and both use the tag of the start address.
- R8: A two-line access reports a hit only when both lines hit. In every other case it reports a single miss and adds at most one to the count.
- R9: A request whose two sets are neither equal nor adjacent raises `err`. It reports neither hit nor miss, changes no tag and leaves the count unchanged.
- R10: `miss_count` is CNT_W bits wide (32 by default). It increases by one on the same edge that registers a miss result, and it holds at its all-ones value once it gets there.
- R11: With WAYS = 1 the block works as a direct-mapped directory: a miss overwrites way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | SIZE_W | Access size in bytes, at least 1 |
| done | output | 1 | One-cycle result pulse |
| hit | output | 1 | Result: hit |
| miss | output | 1 | Result: miss |
| err | output | 1 | Result: sets not adjacent |
| miss_count | output | CNT_W | Saturating miss counter |

## Verification
The bench first confirms that tag 0 hits straight after reset. It then walks one set through hit-in-way-1 promotions and evictions of the oldest way. A design that reversed the shift order, or that failed to move a promoted tag, would hit where the expected result is a miss. Two-line accesses cover both-miss, both-hit and one-line-miss cases, and one of them wraps from the last set to set 0. A follow-up lookup with the end-address tag shows that the second line was installed with the start tag. Other cases:
- Non-adjacent spans: a design that updated tags on an error would evict a tag that the bench later expects to hit.
- Counter saturation: a design that wrapped the counter would fall back to zero.
- Direct-mapped instance: a design that mishandled one way would keep a stale tag.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND
    } tagdir_state_e;

    typedef enum logic [1:0] {
        AC_ONE_LINE,
        AC_TWO_LINES,
        AC_BAD_SPAN
    } tagdir_span_e;

endpackage

// File: rtl/tagdir_span_decode.sv
module tagdir_span_decode
    import tagdir_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 8,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = ADDR_W - OFF_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic [IDX_W-1:0]  first_set,
    output logic [IDX_W-1:0]  second_set,
    output logic [TAG_W-1:0]  tag,
    output tagdir_span_e      span
);

    logic [ADDR_W-1:0] last_byte;
    logic [IDX_W-1:0]  next_set;
    logic              unused_bits;

    always_comb begin
        last_byte  = addr + ADDR_W'(size) - ADDR_W'(1);
        first_set  = addr[OFF_W +: IDX_W];
        second_set = last_byte[OFF_W +: IDX_W];
        // power-of-two set count: overflow of the add is the modulo
        next_set   = first_set + IDX_W'(1);
        tag        = addr[ADDR_W-1 -: TAG_W];
        if (second_set == first_set) begin
            span = AC_ONE_LINE;
        end else if (second_set == next_set) begin
            span = AC_TWO_LINES;
        end else begin
            span = AC_BAD_SPAN;
        end
    end

    assign unused_bits = ^{addr[OFF_W-1:0], last_byte[OFF_W-1:0],
                           last_byte[ADDR_W-1 -: TAG_W]};

endmodule

// File: rtl/tagdir_set_update.sv
module tagdir_set_update #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 25
) (
    input  logic [WAYS-1:0][TAG_W-1:0] row_in,
    input  logic [TAG_W-1:0]           tag,
    output logic                       found,
    output logic [WAYS-1:0][TAG_W-1:0] row_out
);

    localparam int PW = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [PW-1:0] pos;

    // lowest matching way wins; without a match the last way is evicted
    always_comb begin
        found = 1'b0;
        pos   = PW'(WAYS - 1);
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (row_in[i] == tag) begin
                found = 1'b1;
                pos   = PW'(i);
            end
        end
    end

    assign row_out[0] = tag;

    generate
        for (genvar j = 1; j < WAYS; j++) begin : g_shift
            assign row_out[j] = (PW'(j) <= pos) ? row_in[j-1] : row_in[j];
        end
    endgenerate

endmodule

// File: rtl/tagdir_miss_ctr.sv
module tagdir_miss_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (bump && count != CNT_MAX) begin
            count <= count + CNT_W'(1);
        end
    end

    assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && count != CNT_MAX) |=> count == $past(count) + CNT_W'(1));

    assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bump |=> $stable(count));

    assert_count_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count == CNT_MAX |=> count == CNT_MAX);

endmodule

// File: rtl/tagdir_lru.sv
module tagdir_lru
    import tagdir_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SIZE_W      = 8,
    parameter int CACHE_BYTES = 256,
    parameter int LINE_BYTES  = 16,
    parameter int WAYS        = 2,
    parameter int CNT_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    output logic              done,
    output logic              hit,
    output logic              miss,
    output logic              err,
    output logic [CNT_W-1:0]  miss_count
);

    localparam int SETS  = CACHE_BYTES / LINE_BYTES / WAYS;
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    tagdir_state_e state_q, state_d;

    logic [IDX_W-1:0] dec_first, dec_second;
    logic [TAG_W-1:0] dec_tag;
    tagdir_span_e     dec_span;

    logic [IDX_W-1:0] set_a_q, set_b_q, cur_set;
    logic [TAG_W-1:0] tag_q;
    tagdir_span_e     span_q;
    logic             first_missed_q;

    logic [WAYS-1:0][TAG_W-1:0] tags_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0] row_rd, row_wr;
    logic                       lk_hit, wr_en, bump, req_fire;

    tagdir_span_decode #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OFF_W(OFF_W),
        .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_decode (
        .addr(req_addr), .size(req_size),
        .first_set(dec_first), .second_set(dec_second),
        .tag(dec_tag), .span(dec_span)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign req_fire  = req_valid && req_ready;
    assign cur_set   = (state_q == ST_SECOND) ? set_b_q : set_a_q;
    assign row_rd    = tags_q[cur_set];

    tagdir_set_update #(.WAYS(WAYS), .TAG_W(TAG_W)) u_update (
        .row_in(row_rd), .tag(tag_q), .found(lk_hit), .row_out(row_wr)
    );

    assign wr_en = ((state_q == ST_FIRST) && (span_q != AC_BAD_SPAN))
                || (state_q == ST_SECOND);
    assign bump  = ((state_q == ST_FIRST) && (span_q == AC_ONE_LINE) && !lk_hit)
                || ((state_q == ST_SECOND) && (first_missed_q || !lk_hit));

    tagdir_miss_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .bump(bump), .count(miss_count)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_fire) state_d = ST_FIRST;              // accept
            ST_FIRST:  state_d = (span_q == AC_TWO_LINES) ? ST_SECOND // continue_span
                                                          : ST_IDLE;  // finish_single / finish_error
            ST_SECOND: state_d = ST_IDLE;                             // finish_span
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and tag storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_a_q        <= '0;
            set_b_q        <= '0;
            tag_q          <= '0;
            span_q         <= AC_ONE_LINE;
            first_missed_q <= 1'b0;
            for (int s = 0; s < SETS; s++) tags_q[s] <= '0;
        end else begin
            if (req_fire) begin
                set_a_q <= dec_first;
                set_b_q <= dec_second;
                tag_q   <= dec_tag;
                span_q  <= dec_span;
            end
            if (state_q == ST_FIRST) first_missed_q <= !lk_hit;
            if (wr_en) tags_q[cur_set] <= row_wr;
        end
    end

    // registered result outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            hit  <= 1'b0;
            miss <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= 1'b0;
            hit  <= 1'b0;
            miss <= 1'b0;
            err  <= 1'b0;
            unique case (state_q)
                ST_IDLE: ;
                ST_FIRST: begin
                    if (span_q == AC_BAD_SPAN) begin
                        done <= 1'b1;
                        err  <= 1'b1;
                    end else if (span_q == AC_ONE_LINE) begin
                        done <= 1'b1;
                        hit  <= lk_hit;
                        miss <= !lk_hit;
                    end
                end
                ST_SECOND: begin
                    done <= 1'b1;
                    hit  <= !first_missed_q && lk_hit;
                    miss <= first_missed_q || !lk_hit;
                end
                default: ;
            endcase
        end
    end

    assert_done_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_accept_goes_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $countones({hit, miss, err}) == 1);

    assert_quiet_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !(hit || miss || err));

    assert_err_no_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> $stable(miss_count));

endmodule

// File: tb/tagdir_lru_bench.sv
module tagdir_lru_bench;

    localparam int ADDR_W = 32;
    localparam int SIZE_W = 8;
    localparam int CNT_W  = 4;
    localparam int CMAX   = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic v_main = 1'b0, v_dm = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [SIZE_W-1:0] size = 8'd1;

    logic rdy_m, done_m, hit_m, miss_m, err_m;
    logic rdy_d, done_d, hit_d, miss_d, err_d;
    logic [CNT_W-1:0] cnt_m, cnt_d;

    int checks = 0, fails = 0;
    int exp_m = 0, exp_d = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    tagdir_lru #(.CNT_W(CNT_W)) u_tagdir_lru (
        .clk(clk), .rst_n(rst_n), .req_valid(v_main), .req_ready(rdy_m),
        .req_addr(addr), .req_size(size), .done(done_m), .hit(hit_m),
        .miss(miss_m), .err(err_m), .miss_count(cnt_m)
    );

    tagdir_lru #(.CNT_W(CNT_W), .WAYS(1)) u_tagdir_lru_dm (
        .clk(clk), .rst_n(rst_n), .req_valid(v_dm), .req_ready(rdy_d),
        .req_addr(addr), .req_size(size), .done(done_d), .hit(hit_d),
        .miss(miss_d), .err(err_d), .miss_count(cnt_d)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Issue one request; outcome: 0 hit, 1 miss, 2 error
    task automatic access(input bit dm, input logic [ADDR_W-1:0] a,
                          input int sz, input int exp_out, input int exp_lat,
                          input string req);
        int lat;
        bit busy_seen;
        logic h, m, e, d;
        int c;
        @(negedge clk);
        addr = a;
        size = SIZE_W'(sz);
        if (dm) v_dm = 1'b1; else v_main = 1'b1;
        @(negedge clk);
        v_dm = 1'b0;
        v_main = 1'b0;
        busy_seen = dm ? !rdy_d : !rdy_m;
        lat = 1;
        d = dm ? done_d : done_m;
        while (!d && lat < 10) begin
            @(negedge clk);
            lat++;
            d = dm ? done_d : done_m;
        end
        h = dm ? hit_d : hit_m;
        m = dm ? miss_d : miss_m;
        e = dm ? err_d : err_m;
        c = dm ? int'(cnt_d) : int'(cnt_m);
        if (exp_out == 1) begin
            if (dm) exp_d = (exp_d < CMAX) ? exp_d + 1 : CMAX;
            else    exp_m = (exp_m < CMAX) ? exp_m + 1 : CMAX;
        end
        chk(busy_seen, "R3", "ready low while busy", int'(!busy_seen), 0);
        chk(lat == exp_lat, "R3", "latency", lat, exp_lat);
        chk(h == (exp_out == 0), req, "hit", int'(h), int'(exp_out == 0));
        chk(m == (exp_out == 1), req, "miss", int'(m), int'(exp_out == 1));
        chk(e == (exp_out == 2), req, "err", int'(e), int'(exp_out == 2));
        chk(c == (dm ? exp_d : exp_m), "R10", "miss_count", c, dm ? exp_d : exp_m);
        @(negedge clk);
        d = dm ? done_d : done_m;
        chk(!d, "R3", "done single pulse", int'(d), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(rdy_m && rdy_d, "R2", "ready after reset", int'(rdy_m), 1);
        chk(!done_m && !done_d, "R2", "done low after reset", int'(done_m), 0);
        chk(cnt_m == 0 && cnt_d == 0, "R2", "count zero", int'(cnt_m), 0);
        access(0, 32'h0000, 4, 0, 2, "R2");   // tag 0 present after reset
    endtask

    task automatic t_lru();
        access(0, 32'h0080, 4, 1, 2, "R6");   // set0 [1,0]
        access(0, 32'h0080, 4, 0, 2, "R1");
        access(0, 32'h0100, 4, 1, 2, "R6");   // [2,1]
        access(0, 32'h0080, 4, 0, 2, "R5");   // way1 hit -> [1,2]
        access(0, 32'h0180, 4, 1, 2, "R6");   // evicts 2 -> [3,1]
        access(0, 32'h0100, 4, 1, 2, "R6");   // [2,3]
        access(0, 32'h0180, 4, 0, 2, "R5");   // [3,2]
        access(0, 32'h0080, 4, 1, 2, "R6");   // [1,3]
    endtask

    task automatic t_span();
        access(0, 32'h0A0E, 4, 1, 3, "R8");   // sets 0,1 both miss: one miss
        access(0, 32'h0A0E, 4, 0, 3, "R8");   // both hit
        access(0, 32'h0A1E, 4, 1, 3, "R8");   // set1 hit, set2 miss
        access(0, 32'h0A20, 1, 0, 2, "R7");   // set2 got start tag
        access(0, 32'h0A7E, 4, 1, 3, "R7");   // wrap set7 -> set0
        access(0, 32'h0A00, 1, 0, 2, "R7");
        access(0, 32'h0A70, 1, 0, 2, "R7");
        access(0, 32'h0A80, 1, 1, 2, "R7");   // end tag never installed
    endtask

    task automatic t_error();
        access(0, 32'h0300, 40, 2, 2, "R9");  // sets 0 and 2
        access(0, 32'h0A00, 1, 0, 2, "R9");   // set0 untouched by error
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 8; k++)
            access(0, ((32'h40 + k) << 7) | 32'h30, 1, 1, 2, "R10");
        chk(cnt_m == CMAX, "R10", "saturated count", int'(cnt_m), CMAX);
    endtask

    task automatic t_direct();
        access(1, 32'h0000, 1, 0, 2, "R11");
        access(1, 32'h0100, 1, 1, 2, "R11");
        access(1, 32'h0100, 1, 0, 2, "R11");
        access(1, 32'h0000, 1, 1, 2, "R11");
        access(1, 32'h0000, 1, 0, 2, "R11");
        access(1, 32'h00FE, 4, 0, 3, "R11");  // wrap 15 -> 0, both hold tag 0
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lru();
        t_span();
        t_error();
        t_saturate();
        t_direct();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule